// File: doc/BRIEF.md
# Clock Source Select and Gating Controller

This unit turns two raw clock-enable tick streams, a fast oscillator tick and a slow crystal tick, into three derived clock-enable pulse streams. The three streams are a main clock for the processor, a sub-main clock for peripherals and an auxiliary clock. Each derived clock has its own source multiplexer and a power-of-two divider. The selections and divide ratios come from byte-wide control registers on a simple peripheral bus.

Four low-power mode bits taken from the processor status word stop individual outputs. Some combinations of these bits also stop a whole oscillator. Every output is a single-cycle enable pulse, driven one clock after the source tick that produced it.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After reset the registers read as follows: address 0x56 reads 0x60, 0x57 reads 0x87, 0x58 reads 0x00 and 0x53 reads 0x05.
- R2: A written register reads back the written byte. `busRdata` follows `busAddr` combinationally. A read from any other address returns 0x00, and a write to any other address changes no register.
- R3: The main clock source is set by bits [7:6] of register 0x58. Codes 00 and 01 pick the fast tick, code 11 picks the slow tick, and code 10 picks no source, so the main output never pulses.
- R4: Each divider pulses once per 2^field selected source ticks: 1, 2, 4 or 8. Each pulse appears in the cycle after the tick that completes the count. The main divide field is bits [5:4] of 0x58, the sub-main field is bits [2:1] of 0x58, and the auxiliary field is bits [5:4] of 0x57.
- R5: Bit 3 of 0x58 picks the sub-main source: 0 picks the fast tick and 1 picks the slow tick.
- R6: The auxiliary clock always divides the slow tick.
- R7: Writing 0x58 restarts the main and sub-main dividers from zero. Writing 0x57 restarts the auxiliary divider. No pulse comes from a count begun before the write.
- R8: While `cpuOff` is set the main output does not pulse.
- R9: While `scg1` is set the sub-main output does not pulse, and the fast oscillator is stopped.
- R10: While `scg0` is set and the sub-main clock uses the slow source, the fast oscillator is stopped. While `scg0` is set and the sub-main clock uses the fast source, the fast oscillator keeps running.
- R11: While `oscOff` is set the slow oscillator is stopped, so no output driven from it pulses. With all four mode bits set, no output pulses.
- R12: Mode bits act on the source tick present in the same cycle as them. A pulse already produced is never cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | Write when high, read when low |
| busAddr | input | 8 | Byte address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from `busAddr` |
| fastTick | input | 1 | Fast oscillator tick enable |
| slowTick | input | 1 | Slow crystal tick enable |
| cpuOff | input | 1 | Mode bit: processor off |
| oscOff | input | 1 | Mode bit: slow oscillator off |
| scg0 | input | 1 | Mode bit: fast oscillator off when the sub-main clock does not use it |
| scg1 | input | 1 | Mode bit: sub-main clock and fast oscillator off |
| mainEn | output | 1 | Main clock enable pulse |
| subEn | output | 1 | Sub-main clock enable pulse |
| auxEn | output | 1 | Auxiliary clock enable pulse |

## Verification
The bench sweeps every combination of the main and sub-main select and divide fields. It feeds 16 fast ticks and 8 slow ticks per sweep point, so a swapped source or an off-by-one divide ratio shows up as a wrong pulse count. The reserved main select code 10 is checked to produce no pulses; a design that mapped it to either oscillator would emit pulses there.

All sixteen mode-bit patterns are run with both sub-main sources. This catches a design that stops the fast oscillator under `scg0` even while the sub-main clock still uses it. It also catches a design that forgets to stop the oscillator when the sub-main clock has moved to the slow source.

The divider restart check writes a register part-way through a count. A divider that kept its old count would then emit an early pulse.

// File: rtl/cgc_pkg.sv
package cgc_pkg;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned ADDR_W = 8;
  parameter int unsigned DIVF_W = 2;
  localparam int unsigned CNT_W = (1 << DIVF_W) - 1;
  localparam int unsigned NUM_CLK = 3;

  localparam logic [ADDR_W-1:0] ADDR_OSC  = ADDR_W'(8'h56);
  localparam logic [ADDR_W-1:0] ADDR_CTL1 = ADDR_W'(8'h57);
  localparam logic [ADDR_W-1:0] ADDR_CTL2 = ADDR_W'(8'h58);
  localparam logic [ADDR_W-1:0] ADDR_CTL3 = ADDR_W'(8'h53);

  localparam logic [DATA_W-1:0] RST_OSC  = DATA_W'(8'h60);
  localparam logic [DATA_W-1:0] RST_CTL1 = DATA_W'(8'h87);
  localparam logic [DATA_W-1:0] RST_CTL2 = DATA_W'(8'h00);
  localparam logic [DATA_W-1:0] RST_CTL3 = DATA_W'(8'h05);

  typedef struct packed {
    logic clrMain;
    logic clrSub;
    logic clrAux;
  } strobe_t;

  typedef struct packed {
    logic [1:0]        mainSel;
    logic [DIVF_W-1:0] mainDiv;
    logic              subSel;
    logic [DIVF_W-1:0] subDiv;
    logic [DIVF_W-1:0] auxDiv;
  } clkcfg_t;
endpackage

// File: rtl/cgc_ctrl.sv
module cgc_ctrl
  import cgc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output clkcfg_t           cfg,
  output strobe_t           strobe
);
  logic [DATA_W-1:0] oscReg, ctl1Reg, ctl2Reg, ctl3Reg;
  logic wrEn;

  assign wrEn = busSel & busWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscReg  <= RST_OSC;
      ctl1Reg <= RST_CTL1;
      ctl2Reg <= RST_CTL2;
      ctl3Reg <= RST_CTL3;
    end else if (wrEn) begin
      unique case (busAddr)
        ADDR_OSC:  oscReg  <= busWdata;
        ADDR_CTL1: ctl1Reg <= busWdata;
        ADDR_CTL2: ctl2Reg <= busWdata;
        ADDR_CTL3: ctl3Reg <= busWdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_OSC:  busRdata = oscReg;
      ADDR_CTL1: busRdata = ctl1Reg;
      ADDR_CTL2: busRdata = ctl2Reg;
      ADDR_CTL3: busRdata = ctl3Reg;
      default:   busRdata = '0;
    endcase
  end

  // Divider restart strobes act in the same cycle as the register write
  assign strobe.clrMain = wrEn && (busAddr == ADDR_CTL2);
  assign strobe.clrSub  = wrEn && (busAddr == ADDR_CTL2);
  assign strobe.clrAux  = wrEn && (busAddr == ADDR_CTL1);

  assign cfg.mainSel = ctl2Reg[7:6];
  assign cfg.mainDiv = ctl2Reg[5:4];
  assign cfg.subSel  = ctl2Reg[3];
  assign cfg.subDiv  = ctl2Reg[2:1];
  assign cfg.auxDiv  = ctl1Reg[5:4];
endmodule

// File: rtl/cgc_divider.sv
module cgc_divider #(
  parameter int unsigned FW  = 2,
  parameter int unsigned CW  = (1 << FW) - 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          tick,
  input  logic [FW-1:0] divSel,
  input  logic          run,
  output logic          pulse
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          wrap;

  assign limit = CW'((32'd1 << divSel) - 32'd1);
  assign wrap  = (cnt == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= tick & wrap & run & ~clr;
      if (clr)       cnt <= '0;
      else if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cgc_datapath.sv
module cgc_datapath
  import cgc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  clkcfg_t cfg,
  input  strobe_t strobe,
  input  logic    fastTick,
  input  logic    slowTick,
  input  logic    cpuOff,
  input  logic    oscOff,
  input  logic    scg0,
  input  logic    scg1,
  output logic    mainEn,
  output logic    subEn,
  output logic    auxEn
);
  logic fastOn, slowOn, fastG, slowG;
  logic [NUM_CLK-1:0]             srcTick, runBit, clrBit, outBit;
  logic [NUM_CLK-1:0][DIVF_W-1:0] divBit;

  // Oscillator stop conditions
  assign slowOn = ~oscOff;
  assign fastOn = ~scg1 & ~(scg0 & cfg.subSel);
  assign fastG  = fastTick & fastOn;
  assign slowG  = slowTick & slowOn;

  always_comb begin
    unique case (cfg.mainSel)
      2'b00, 2'b01: srcTick[0] = fastG;
      2'b11:        srcTick[0] = slowG;
      default:      srcTick[0] = 1'b0;
    endcase
  end
  assign srcTick[1] = cfg.subSel ? slowG : fastG;
  assign srcTick[2] = slowG;

  assign runBit = {1'b1, ~scg1, ~cpuOff};
  assign clrBit = {strobe.clrAux, strobe.clrSub, strobe.clrMain};
  assign divBit = {cfg.auxDiv, cfg.subDiv, cfg.mainDiv};

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_div
    cgc_divider #(.FW(DIVF_W), .CW(CNT_W)) u_div (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (clrBit[i]),
      .tick  (srcTick[i]),
      .divSel(divBit[i]),
      .run   (runBit[i]),
      .pulse (outBit[i])
    );
  end

  assign mainEn = outBit[0];
  assign subEn  = outBit[1];
  assign auxEn  = outBit[2];
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
  import cgc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              fastTick,
  input  logic              slowTick,
  input  logic              cpuOff,
  input  logic              oscOff,
  input  logic              scg0,
  input  logic              scg1,
  output logic              mainEn,
  output logic              subEn,
  output logic              auxEn
);
  clkcfg_t cfg;
  strobe_t strobe;

  cgc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cfg(cfg), .strobe(strobe)
  );

  cgc_datapath u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strobe(strobe),
    .fastTick(fastTick), .slowTick(slowTick),
    .cpuOff(cpuOff), .oscOff(oscOff), .scg0(scg0), .scg1(scg1),
    .mainEn(mainEn), .subEn(subEn), .auxEn(auxEn)
  );
endmodule

// File: rtl/cgc_checker.sv
module cgc_checker
  import cgc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              fastTick,
  input logic              slowTick,
  input logic              cpuOff,
  input logic              oscOff,
  input logic              scg1,
  input logic              mainEn,
  input logic              subEn,
  input logic              auxEn
);
  logic mapped;
  assign mapped = (busAddr == ADDR_OSC) || (busAddr == ADDR_CTL1) ||
                  (busAddr == ADDR_CTL2) || (busAddr == ADDR_CTL3);

  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> busRdata == '0);
  a_r8_main_stopped: assert property (@(posedge clk) disable iff (!rstN)
    cpuOff |=> !mainEn);
  a_r9_sub_stopped: assert property (@(posedge clk) disable iff (!rstN)
    scg1 |=> !subEn);
  a_r11_aux_stopped: assert property (@(posedge clk) disable iff (!rstN)
    oscOff |=> !auxEn);
  a_r6_aux_after_slow: assert property (@(posedge clk) disable iff (!rstN)
    auxEn |-> $past(slowTick));
  a_r4_main_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    mainEn |-> $past(fastTick || slowTick));
endmodule

bind clk_gate_ctrl cgc_checker u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdata(busRdata),
  .fastTick(fastTick), .slowTick(slowTick), .cpuOff(cpuOff),
  .oscOff(oscOff), .scg1(scg1), .mainEn(mainEn), .subEn(subEn),
  .auxEn(auxEn)
);

// File: tb/sim_clk_gate_ctrl.sv
`timescale 1ns/1ps
module sim_clk_gate_ctrl;
  logic clk = 0, rstN = 0;
  logic busSel = 0, busWr = 0;
  logic [7:0] busAddr = 0, busWdata = 0, busRdata;
  logic fastTick = 0, slowTick = 0;
  logic cpuOff = 0, oscOff = 0, scg0 = 0, scg1 = 0;
  logic mainEn, subEn, auxEn;
  int nChk = 0, nFail = 0;
  int cMain = 0, cSub = 0, cAux = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clk_gate_ctrl u0 (.*);

  always @(negedge clk) begin
    if (mainEn) cMain++;
    if (subEn)  cSub++;
    if (auxEn)  cAux++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    busAddr = a;
    #1 chk(tag, int'(busRdata), int'(exp));
  endtask

  task automatic runTicks(input int fN, input int sN);
    cMain = 0; cSub = 0; cAux = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); fastTick = (i < fN); slowTick = (i < sN);
      @(negedge clk); fastTick = 0; slowTick = 0;
    end
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset values
    rdChk("R1 osc", 8'h56, 8'h60);
    rdChk("R1 ctl1", 8'h57, 8'h87);
    rdChk("R1 ctl2", 8'h58, 8'h00);
    rdChk("R1 ctl3", 8'h53, 8'h05);
    // R2 readback, unmapped access
    wrReg(8'h53, 8'hA5); rdChk("R2 ctl3 rb", 8'h53, 8'hA5);
    wrReg(8'h56, 8'h3C); rdChk("R2 osc rb", 8'h56, 8'h3C);
    wrReg(8'h55, 8'hFF); rdChk("R2 unmapped rd", 8'h55, 8'h00);
    rdChk("R2 osc kept", 8'h56, 8'h3C);
    rdChk("R2 ctl3 kept", 8'h53, 8'hA5);
    rdChk("R2 ctl2 kept", 8'h58, 8'h00);
    rdChk("R2 ctl1 kept", 8'h57, 8'h87);
    rdChk("R2 unmapped 00", 8'h00, 8'h00);

    // R3 R4 R5: sweep every main/sub select and divide setting
    for (int v = 0; v < 128; v++) begin
      int ms, md, ss, sd, em, es;
      ms = (v >> 5) & 3; md = (v >> 3) & 3; ss = (v >> 2) & 1; sd = v & 3;
      wrReg(8'h58, 8'(v << 1));
      runTicks(16, 8);
      em = (ms == 2) ? 0 : ((ms == 3) ? (8 >> md) : (16 >> md));
      es = ss ? (8 >> sd) : (16 >> sd);
      chk("R3/R4 main count", cMain, em);
      chk("R5/R4 sub count", cSub, es);
      chk("R6 aux count", cAux, 8);
    end

    // R6 R4 aux divider sweep
    for (int d = 0; d < 4; d++) begin
      wrReg(8'h57, 8'(8'h87 | (d << 4)));
      runTicks(16, 8);
      chk("R6/R4 aux div", cAux, 8 >> d);
    end

    // R7 divider restart on write
    wrReg(8'h58, 8'h30);
    runTicks(3, 0);
    wrReg(8'h58, 8'h30);
    runTicks(7, 0);
    chk("R7 main restart", cMain, 0);
    runTicks(1, 0);
    chk("R7 main completes", cMain, 1);
    wrReg(8'h57, 8'hB7);
    runTicks(0, 3);
    wrReg(8'h57, 8'hB7);
    runTicks(0, 7);
    chk("R7 aux restart", cAux, 0);
    wrReg(8'h57, 8'h87);

    // R8-R12: all mode patterns with both sub sources
    for (int ss = 0; ss < 2; ss++) begin
      wrReg(8'h58, 8'(ss << 3));
      for (int m = 0; m < 16; m++) begin
        bit c, o, s0, s1, fOn, sOn;
        int em, es, ea;
        c = m[0]; o = m[1]; s0 = m[2]; s1 = m[3];
        @(negedge clk);
        cpuOff = c; oscOff = o; scg0 = s0; scg1 = s1;
        runTicks(16, 8);
        fOn = !s1 && !(s0 && ss == 1);
        sOn = !o;
        em = (!c && fOn) ? 16 : 0;
        es = s1 ? 0 : (ss ? (sOn ? 8 : 0) : (fOn ? 16 : 0));
        ea = sOn ? 8 : 0;
        chk("R8/R10 main gated", cMain, em);
        chk("R9/R10 sub gated", cSub, es);
        chk("R11 aux gated", cAux, ea);
      end
    end

    // R12 mode change between ticks: pulse kept, next tick gated
    @(negedge clk); cpuOff = 0; oscOff = 0; scg0 = 0; scg1 = 0;
    wrReg(8'h58, 8'h00);
    cMain = 0;
    @(negedge clk); fastTick = 1;
    @(negedge clk); fastTick = 0; cpuOff = 1;
    @(negedge clk); fastTick = 1;
    @(negedge clk); fastTick = 0;
    @(negedge clk); @(negedge clk);
    chk("R12 gate at next tick", cMain, 1);
    cpuOff = 0;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule